// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block walks a shared table of 64 conversion command words on behalf of two queues. Queue 1 owns the words from index 0 up to, but not including, a programmable split index. Queue 2 owns the words from the split index to the end of the table. Each queue has its own trigger input and its own start mode. For every word it selects, the block raises a conversion request and waits for a done pulse from the converter. It reads two flags for the word under the pointer: pause and end-of-queue.

Queue 1 has priority over queue 2. A pending queue 1 trigger suspends a running queue 2. Queue 2 then resumes at the same word once queue 1 finishes or pauses. Software sees three things:
- a read-only word pointer;
- one 4-bit status field in which the states of the two queues are interlinked;
- a sticky overrun flag per queue, which records triggers that arrived while that queue was busy and were discarded.

A stop control returns everything to idle with the pointer at 0. A freeze control holds all state exactly as it is.

Top module: `dq_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `cw_ptr` is 0, `q_status` is 4'b0000, `ovr_flag` is 2'b00 and `conv_req` is 0.
- R2: `q_status[3:2]` encodes queue 1 as idle 00, paused 01, active 10, trigger pending 11. `q_status[1:0]` encodes queue 2 as idle 00, paused 01, pending 11, and 10, where 10 means active when queue 1 is idle or paused, and suspended when queue 1 is active or pending.
- R3: A trigger on an idle or paused queue makes it pending at the next edge. At the following edge, when no queue is active or launching, `cw_ptr` loads the queue's resume index (0 or the split index for a fresh start). The status shows active one edge after that.
- R4: When the done pulse completes a word whose pause flag is set, the queue becomes paused and `cw_ptr` stays on that word until a trigger arrives. A later trigger resumes the queue at the next word.
- R5: An active queue that reads a word with the end-of-queue flag ends with `cw_ptr` left on that word. In the software single-scan mode (mode 00) and the hardware modes (10, 11) the queue goes idle. In the software continuous mode (mode 01) it goes pending again at its start index.
- R6: Queue 1 ends when `cw_ptr` equals the split index `q2_base`, and `cw_ptr` keeps showing that index.
- R7: When word 63 completes without a pause, `cw_ptr` wraps to 0 and the queue ends on the next cycle with `cw_ptr` still at 0.
- R8: At most one queue is active at a time. While queue 2 is active, a pending queue 1 suspends it. Queue 2 resumes at the suspended word once queue 1 is no longer active or pending.
- R9: In the hardware modes (mode bit 1 set), a trigger that arrives while its queue is active, suspended or pending sets that queue's overrun flag at the next edge. The trigger is dropped and the queue state is unchanged.
- R10: In the software modes (mode bit 1 clear), a trigger never sets the overrun flag.
- R11: An overrun flag clears only through `ovr_clr` after an `ovr_read` pulse that saw it set. A clear without that earlier read leaves the flag at 1. A set in the same cycle as a clear wins.
- R12: While `stop_req` is high, both queues go idle and `cw_ptr` goes to 0 at the next edge. The overrun flags keep their values.
- R13: While `freeze_req` is high, `cw_ptr`, the queue states and the overrun flags hold, `conv_req` is 0, and triggers and done pulses are ignored.
- R14: `conv_req` is 1 exactly when a queue is active on a word that does not end it and no suspension is due. A `conv_done` pulse on a word without a pause flag advances `cw_ptr` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q2_base | input | 6 | Split index: first word of queue 2 |
| q1_mode | input | 2 | Queue 1 mode: 00 sw single, 01 sw continuous, 10 external, 11 timer |
| q2_mode | input | 2 | Queue 2 mode, same encoding |
| q1_trig | input | 1 | Queue 1 trigger pulse |
| q2_trig | input | 1 | Queue 2 trigger pulse |
| cw_pause | input | 1 | Pause flag of the word at `cw_ptr` |
| cw_eoq | input | 1 | End-of-queue flag of the word at `cw_ptr` |
| conv_done | input | 1 | Converter finished the requested word |
| stop_req | input | 1 | Stop: reset sequencing state |
| freeze_req | input | 1 | Freeze: hold all state |
| ovr_read | input | 1 | Software read strobe of the overrun flags |
| ovr_clr | input | 2 | Write-zero strobes, bit 0 queue 1, bit 1 queue 2 |
| conv_req | output | 1 | Conversion request for word `cw_ptr` |
| cw_ptr | output | 6 | Command word pointer |
| q_status | output | 4 | Interlinked queue status field |
| ovr_flag | output | 2 | Sticky overrun flags, bit 0 queue 1, bit 1 queue 2 |

## Verification
The bench checks the pointer and the status field on separate cycles across the launch gap. A design that moved both together would be off by one cycle at every start. It runs queue 1 up to the split index, and queue 2 across word 63 into the wrap. A design that ran past the split index, or ended without showing 0, would leave the wrong pointer. It preempts queue 2 and resumes it, so a design that restarted queue 2 at its base, or skipped the suspended word, would show a wrong index. It also probes overrun clearing without a prior read, triggers in a software mode, and triggers and done pulses under freeze. A design that cleared, set or advanced in any of these cases would differ from the expected flags or pointer.

// File: rtl/dqs_pkg.sv
// Package: shared types for the dual-queue command sequencer.
// Assumes two queues; queue index 0 is queue 1 and has priority.
package dqs_pkg;
    localparam int NQ = 2;

    typedef enum logic [2:0] {
        QS_IDLE,
        QS_ACTIVE,
        QS_PAUSED,
        QS_SUSP,
        QS_PEND
    } qstate_t;

    typedef enum logic [1:0] {
        LN_NONE,
        LN_Q1,
        LN_Q2
    } launch_t;

    localparam logic [1:0] MD_SW_ONCE = 2'b00;
    localparam logic [1:0] MD_SW_CONT = 2'b01;
endpackage

// File: rtl/dqs_trig_gate.sv
// Module: qualifies one queue's trigger into a start request or an
// overrun event. Assumes trig is a one-cycle pulse; hw_src is mode bit 1.
module dqs_trig_gate
    import dqs_pkg::*;
(
    input  logic    trig,
    input  logic    hw_src,
    input  logic    stop,
    input  logic    freeze,
    input  qstate_t st,
    output logic    start_req,
    output logic    ovr_evt
);
    logic live;
    logic busy;

    // Decode whether the trigger may act and whether the queue is busy.
    always_comb begin
        live      = trig && !stop && !freeze;
        busy      = (st == QS_ACTIVE) || (st == QS_SUSP) || (st == QS_PEND);
        start_req = live && ((st == QS_IDLE) || (st == QS_PAUSED));
        ovr_evt   = live && hw_src && busy;
    end
endmodule

// File: rtl/dqs_ovr_flag.sv
// Module: sticky overrun flag for one queue. Software clears it by a
// read that saw it set, then a clear strobe. Set beats clear.
module dqs_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_stb,
    input  logic clr_stb,
    output logic flag
);
    logic armed;

    // Track flag and read-arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set_evt) begin
                flag <= 1'b1;
            end else if (clr_stb && armed) begin
                flag <= 1'b0;
            end
            if (clr_stb && armed) begin
                armed <= 1'b0;
            end else if (rd_stb) begin
                armed <= flag;
            end
        end
    end

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(clr_stb && armed)) |=> flag);
endmodule

// File: rtl/dqs_engine.sv
// Module: queue state machines, launch stage and pointer for the shared
// command table. Assumes cw_pause/cw_eoq describe the word at cwp in the
// same cycle, and that at most one conv_done arrives per request.
module dqs_engine
    import dqs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             freeze,
    input  logic [IDX_W-1:0] q2_base,
    input  logic [NQ-1:0]    start_req,
    input  logic [NQ-1:0]    cont,
    input  logic             cw_pause,
    input  logic             cw_eoq,
    input  logic             conv_done,
    output qstate_t          q1_st,
    output qstate_t          q2_st,
    output logic [IDX_W-1:0] cwp,
    output logic             conv_req
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    qstate_t          n_st1, n_st2;
    launch_t          launch, n_launch;
    logic [IDX_W-1:0] pos1, pos2, n_pos1, n_pos2, n_cwp;
    logic             pw1, pw2, n_pw1, n_pw2, wrap, n_wrap;
    logic             end_now, any_act, q2_yield;

    // Detect the end conditions for the word under the pointer.
    always_comb begin
        end_now  = wrap || cw_eoq || ((q1_st == QS_ACTIVE) && (cwp == q2_base));
        any_act  = (q1_st == QS_ACTIVE) || (q2_st == QS_ACTIVE);
        q2_yield = (q2_st == QS_ACTIVE) && (q1_st == QS_PEND);
        conv_req = !stop && !freeze && any_act && !q2_yield && !end_now;
    end

    // Next-state for both queues, the launch stage and the pointer.
    always_comb begin
        n_st1 = q1_st;  n_st2 = q2_st;
        n_pos1 = pos1;  n_pos2 = pos2;
        n_pw1 = pw1;    n_pw2 = pw2;
        n_cwp = cwp;    n_wrap = wrap;
        n_launch = launch;
        if (stop) begin
            n_st1 = QS_IDLE;  n_st2 = QS_IDLE;
            n_pos1 = '0;      n_pos2 = '0;
            n_pw1 = 1'b0;     n_pw2 = 1'b0;
            n_cwp = '0;       n_wrap = 1'b0;
            n_launch = LN_NONE;
        end else if (!freeze) begin
            // launch completes: queue becomes visibly active
            if (launch == LN_Q1) n_st1 = QS_ACTIVE;
            if (launch == LN_Q2) n_st2 = QS_ACTIVE;
            n_launch = LN_NONE;
            // execution of the active queue
            if (q1_st == QS_ACTIVE) begin
                if (end_now) begin
                    n_wrap = 1'b0;
                    if (cont[0]) begin
                        n_st1 = QS_PEND; n_pos1 = '0; n_pw1 = 1'b0;
                    end else begin
                        n_st1 = QS_IDLE;
                    end
                end else if (conv_done) begin
                    if (cw_pause) begin
                        n_st1 = QS_PAUSED;
                        n_pos1 = cwp + 1'b1;
                        n_pw1 = (cwp == LAST_IDX);
                    end else begin
                        n_cwp = cwp + 1'b1;
                        n_wrap = (cwp == LAST_IDX);
                    end
                end
            end else if (q2_st == QS_ACTIVE) begin
                if (q2_yield) begin
                    n_st2 = QS_SUSP; n_pos2 = cwp; n_pw2 = wrap; n_wrap = 1'b0;
                end else if (end_now) begin
                    n_wrap = 1'b0;
                    if (cont[1]) begin
                        n_st2 = QS_PEND; n_pos2 = q2_base; n_pw2 = 1'b0;
                    end else begin
                        n_st2 = QS_IDLE;
                    end
                end else if (conv_done) begin
                    if (cw_pause) begin
                        n_st2 = QS_PAUSED;
                        n_pos2 = cwp + 1'b1;
                        n_pw2 = (cwp == LAST_IDX);
                    end else begin
                        n_cwp = cwp + 1'b1;
                        n_wrap = (cwp == LAST_IDX);
                    end
                end
            end
            // accepted triggers: fresh start or resume after pause
            if (start_req[0]) begin
                if (q1_st == QS_IDLE) begin
                    n_pos1 = '0; n_pw1 = 1'b0;
                end
                n_st1 = QS_PEND;
            end
            if (start_req[1]) begin
                if (q2_st == QS_IDLE) begin
                    n_pos2 = q2_base; n_pw2 = 1'b0;
                end
                n_st2 = QS_PEND;
            end
            // grant the engine: pointer moves one cycle before status
            if ((launch == LN_NONE) && !any_act) begin
                if (q1_st == QS_PEND) begin
                    n_launch = LN_Q1; n_cwp = pos1; n_wrap = pw1;
                end else if ((q2_st == QS_PEND) || (q2_st == QS_SUSP)) begin
                    n_launch = LN_Q2; n_cwp = pos2; n_wrap = pw2;
                end
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1_st <= QS_IDLE;  q2_st <= QS_IDLE;
            pos1 <= '0;        pos2 <= '0;
            pw1 <= 1'b0;       pw2 <= 1'b0;
            cwp <= '0;         wrap <= 1'b0;
            launch <= LN_NONE;
        end else begin
            q1_st <= n_st1;    q2_st <= n_st2;
            pos1 <= n_pos1;    pos2 <= n_pos2;
            pw1 <= n_pw1;      pw2 <= n_pw2;
            cwp <= n_cwp;      wrap <= n_wrap;
            launch <= n_launch;
        end
    end

    // R13
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !stop) |=> ($stable(cwp) && $stable(q1_st) && $stable(q2_st)));

    // R12
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cwp == '0 && q1_st == QS_IDLE && q2_st == QS_IDLE));

    // R8
    single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((q1_st == QS_ACTIVE) && (q2_st == QS_ACTIVE)));

    // R14
    req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> ((q1_st == QS_ACTIVE) || (q2_st == QS_ACTIVE)));
endmodule

// File: rtl/dqs_status.sv
// Module: packs both queue states into the interlinked 4-bit field.
// Assumes queue 1 is never suspended; queue 2 code 10 doubles as suspended.
module dqs_status
    import dqs_pkg::*;
(
    input  qstate_t    q1_st,
    input  qstate_t    q2_st,
    output logic [3:0] q_status
);
    // Encode queue 1 in the upper pair and queue 2 in the lower pair.
    always_comb begin
        unique case (q1_st)
            QS_PAUSED: q_status[3:2] = 2'b01;
            QS_ACTIVE: q_status[3:2] = 2'b10;
            QS_PEND:   q_status[3:2] = 2'b11;
            default:   q_status[3:2] = 2'b00;
        endcase
        unique case (q2_st)
            QS_PAUSED:           q_status[1:0] = 2'b01;
            QS_ACTIVE, QS_SUSP:  q_status[1:0] = 2'b10;
            QS_PEND:             q_status[1:0] = 2'b11;
            default:             q_status[1:0] = 2'b00;
        endcase
    end
endmodule

// File: rtl/dq_cmd_seq.sv
// Module: top of the dual-queue command sequencer. Gates each queue's
// trigger, keeps overrun flags, runs the shared engine and packs status.
// Assumes the table owner returns the flags of word cw_ptr combinationally.
module dq_cmd_seq
    import dqs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] q2_base,
    input  logic [1:0]       q1_mode,
    input  logic [1:0]       q2_mode,
    input  logic             q1_trig,
    input  logic             q2_trig,
    input  logic             cw_pause,
    input  logic             cw_eoq,
    input  logic             conv_done,
    input  logic             stop_req,
    input  logic             freeze_req,
    input  logic             ovr_read,
    input  logic [1:0]       ovr_clr,
    output logic             conv_req,
    output logic [IDX_W-1:0] cw_ptr,
    output logic [3:0]       q_status,
    output logic [1:0]       ovr_flag
);
    logic [NQ-1:0] trig_v, hw_v, cont_v, start_v, evt_v;
    qstate_t       st_v [NQ];
    qstate_t       q1_st, q2_st;

    // Gather per-queue inputs into vectors.
    always_comb begin
        trig_v   = {q2_trig, q1_trig};
        hw_v     = {q2_mode[1], q1_mode[1]};
        cont_v   = {q2_mode == MD_SW_CONT, q1_mode == MD_SW_CONT};
        st_v[0]  = q1_st;
        st_v[1]  = q2_st;
    end

    for (genvar gi = 0; gi < NQ; gi++) begin : g_q
        dqs_trig_gate u_gate (
            .trig      (trig_v[gi]),
            .hw_src    (hw_v[gi]),
            .stop      (stop_req),
            .freeze    (freeze_req),
            .st        (st_v[gi]),
            .start_req (start_v[gi]),
            .ovr_evt   (evt_v[gi])
        );
        dqs_ovr_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt_v[gi]),
            .rd_stb  (ovr_read),
            .clr_stb (ovr_clr[gi]),
            .flag    (ovr_flag[gi])
        );
    end

    dqs_engine #(.IDX_W(IDX_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (stop_req),
        .freeze    (freeze_req),
        .q2_base   (q2_base),
        .start_req (start_v),
        .cont      (cont_v),
        .cw_pause  (cw_pause),
        .cw_eoq    (cw_eoq),
        .conv_done (conv_done),
        .q1_st     (q1_st),
        .q2_st     (q2_st),
        .cwp       (cw_ptr),
        .conv_req  (conv_req)
    );

    dqs_status u_status (
        .q1_st    (q1_st),
        .q2_st    (q2_st),
        .q_status (q_status)
    );

    // R10
    sw_mode_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q1_mode[1] && !ovr_flag[0]) |=> !ovr_flag[0]);
endmodule

// File: tb/test_dq_cmd_seq.sv
// Bench: vector table for a two-queue scenario, then directed corner tests.
module test_dq_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] q2_base;
    logic [1:0] q1_mode, q2_mode, ovr_clr, ovr_flag;
    logic       q1_trig, q2_trig, conv_done, stop_req, freeze_req, ovr_read;
    logic       conv_req, cw_pause, cw_eoq;
    logic [5:0] cw_ptr;
    logic [3:0] q_status;
    int         nchk = 0;
    int         nfail = 0;
    bit         fin = 1'b0;

    always #2.5 clk = ~clk;

    // command table model: pause on word 2, end code on word 10
    assign cw_pause = (cw_ptr == 6'd2);
    assign cw_eoq   = (cw_ptr == 6'd10);

    dq_cmd_seq i_dq_cmd_seq (
        .clk(clk), .rst_n(rst_n), .q2_base(q2_base), .q1_mode(q1_mode),
        .q2_mode(q2_mode), .q1_trig(q1_trig), .q2_trig(q2_trig),
        .cw_pause(cw_pause), .cw_eoq(cw_eoq), .conv_done(conv_done),
        .stop_req(stop_req), .freeze_req(freeze_req), .ovr_read(ovr_read),
        .ovr_clr(ovr_clr), .conv_req(conv_req), .cw_ptr(cw_ptr),
        .q_status(q_status), .ovr_flag(ovr_flag)
    );

    // fields: [14] t1 [13] t2 [12] done [11:6] cwp [5:2] status [1:0] ovr
    localparam int NV = 27;
    localparam logic [14:0] VEC [NV] = '{
        {3'b100, 6'd0,  4'b1100, 2'b00},
        {3'b000, 6'd0,  4'b1100, 2'b00},
        {3'b000, 6'd0,  4'b1000, 2'b00},
        {3'b001, 6'd1,  4'b1000, 2'b00},
        {3'b001, 6'd2,  4'b1000, 2'b00},
        {3'b001, 6'd2,  4'b0100, 2'b00},
        {3'b010, 6'd2,  4'b0111, 2'b00},
        {3'b000, 6'd8,  4'b0111, 2'b00},
        {3'b000, 6'd8,  4'b0110, 2'b00},
        {3'b001, 6'd9,  4'b0110, 2'b00},
        {3'b100, 6'd9,  4'b1110, 2'b00},
        {3'b000, 6'd9,  4'b1110, 2'b00},
        {3'b010, 6'd3,  4'b1110, 2'b10},
        {3'b000, 6'd3,  4'b1010, 2'b10},
        {3'b001, 6'd4,  4'b1010, 2'b10},
        {3'b001, 6'd5,  4'b1010, 2'b10},
        {3'b001, 6'd6,  4'b1010, 2'b10},
        {3'b001, 6'd7,  4'b1010, 2'b10},
        {3'b001, 6'd8,  4'b1010, 2'b10},
        {3'b000, 6'd8,  4'b0010, 2'b10},
        {3'b000, 6'd9,  4'b0010, 2'b10},
        {3'b000, 6'd9,  4'b0010, 2'b10},
        {3'b001, 6'd10, 4'b0010, 2'b10},
        {3'b000, 6'd10, 4'b0000, 2'b10},
        {3'b100, 6'd10, 4'b1100, 2'b10},
        {3'b100, 6'd0,  4'b1100, 2'b11},
        {3'b000, 6'd0,  4'b1000, 2'b11}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        q1_trig = 0; q2_trig = 0; conv_done = 0; ovr_read = 0; ovr_clr = 2'b00;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; q2_base = 6'd8; q1_mode = 2'b10; q2_mode = 2'b10;
        q1_trig = 0; q2_trig = 0; conv_done = 0; stop_req = 0; freeze_req = 0;
        ovr_read = 0; ovr_clr = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 reset pointer", 8'(cw_ptr), 8'd0);
        chk("R1 reset status", 8'(q_status), 8'd0);
        chk("R1 reset overrun", 8'(ovr_flag), 8'd0);
        chk("R1 reset request", 8'(conv_req), 8'd0);
        rst_n = 1;

        // table walk: pause, resume, preemption of queue 2, boundary, end code
        for (int i = 0; i < NV; i++) begin
            q1_trig = VEC[i][14]; q2_trig = VEC[i][13]; conv_done = VEC[i][12];
            tick();
            chk("R3 R4 R6 R8 pointer", 8'(cw_ptr), 8'(VEC[i][11:6]));
            chk("R2 R8 status", 8'(q_status), 8'(VEC[i][5:2]));
            chk("R9 overrun", 8'(ovr_flag), 8'(VEC[i][1:0]));
        end

        // R11: clear without prior read is ignored, read then clear works
        ovr_clr = 2'b01; tick();
        chk("R11 clear without read", 8'(ovr_flag), 8'b11);
        ovr_read = 1; tick();
        chk("R11 after read", 8'(ovr_flag), 8'b11);
        ovr_clr = 2'b01; tick();
        chk("R11 read then clear", 8'(ovr_flag), 8'b10);

        // R10: software mode, busy queue 1 retriggered
        q1_mode = 2'b00; q1_trig = 1; tick();
        chk("R10 no overrun in sw mode", 8'(ovr_flag), 8'b10);
        chk("R10 state unchanged", 8'(q_status), 8'b1000);
        chk("R14 request on active word", 8'(conv_req), 8'd1);

        // R13: freeze ignores trigger and done
        freeze_req = 1; conv_done = 1; q2_trig = 1;
        #1 chk("R13 request low in freeze", 8'(conv_req), 8'd0);
        tick();
        chk("R13 pointer held", 8'(cw_ptr), 8'd0);
        chk("R13 status held", 8'(q_status), 8'b1000);
        chk("R13 flags held", 8'(ovr_flag), 8'b10);
        freeze_req = 0; conv_done = 1; tick();
        chk("R14 done advances", 8'(cw_ptr), 8'd1);

        // R12: stop
        stop_req = 1; tick(); stop_req = 0;
        chk("R12 stop pointer", 8'(cw_ptr), 8'd0);
        chk("R12 stop status", 8'(q_status), 8'd0);
        chk("R12 flags kept", 8'(ovr_flag), 8'b10);

        // R7: queue 2 from 62 across the table end
        q2_base = 6'd62; q2_trig = 1; tick(); tick(); tick();
        chk("R3 queue 2 start index", 8'(cw_ptr), 8'd62);
        chk("R14 request at 62", 8'(conv_req), 8'd1);
        conv_done = 1; tick();
        conv_done = 1; tick();
        chk("R7 wrapped pointer", 8'(cw_ptr), 8'd0);
        chk("R7 still active", 8'(q_status), 8'b0010);
        chk("R7 no request at wrap", 8'(conv_req), 8'd0);
        tick();
        chk("R7 end pointer", 8'(cw_ptr), 8'd0);
        chk("R7 end status", 8'(q_status), 8'd0);

        // R5 and R6: continuous queue 1 ends at split index and restarts
        q2_base = 6'd2; q1_mode = 2'b01; q1_trig = 1; tick(); tick(); tick();
        chk("R3 queue 1 active", 8'(q_status), 8'b1000);
        conv_done = 1; tick();
        conv_done = 1; tick();
        chk("R6 reached split", 8'(cw_ptr), 8'd2);
        tick();
        chk("R6 pointer at split", 8'(cw_ptr), 8'd2);
        chk("R5 continuous restart", 8'(q_status), 8'b1100);
        tick();
        chk("R5 restart index", 8'(cw_ptr), 8'd0);

        fin = 1'b1;
        finish_run();
    end
endmodule